// File: doc/BRIEF.md
# Aperture Page Remapping Table

This block redirects I/O virtual addresses that fall inside one fixed window onto physical memory, one 4 KiB page at a time. The window starts at a base address and spans a parameterised number of pages. Each page has a 32-bit table entry. The entry holds a valid flag in bit 31 and the physical page frame in bits 30..12. The low 12 bits of every address pass straight through.

Software reaches the table one entry at a time through three registers. It first loads an I/O virtual address into an entry-pointer register. After that, writes and reads of the entry-data register act on the entry that the pointer selects. A configuration register holds the translation state. The block keeps this state in a two-state machine with the states `XL_OFF` and `XL_ON`. A write to the configuration register with bit 0 set takes `XL_OFF` to `XL_ON`, and a write with bit 0 clear takes `XL_ON` back to `XL_OFF`. All other cycles hold the state.

A lookup port accepts an address. One cycle later it returns either the translated physical address or a fault.

Top module: `aprt_remap`

## Requirements
- R1: After reset the configuration register reads 0, the state is `XL_OFF`, every entry is invalid and the entry pointer holds 0.
- R2: A write to offset 0x0 with bit 0 set enters `XL_ON`, and one with bit 0 clear enters `XL_OFF`. A read of offset 0x0 returns 1 in `XL_ON` and 0 in `XL_OFF`, in bit 0, with all other bits zero.
- R3: A write to offset 0x4 latches the full 32-bit entry pointer. A read of offset 0x4 returns the latched pointer.
- R4: A write to offset 0x8 stores the 32-bit data into entry (pointer − BASE) >> 12. A read of offset 0x8 returns that entry. Read data appears on `reg_rdata` with `reg_rack` high one cycle after the read strobe.
- R5: When the pointer lies outside [BASE, BASE + PAGES×4096 − 1], writes to offset 0x8 change no entry and reads of offset 0x8 return 0.
- R6: A lookup that hits a valid entry in `XL_ON` raises `lk_rsp` one cycle after `lk_req`. It returns `lk_fault` = 0 and `lk_paddr` = {0, entry[30:12], address[11:0]}.
- R7: A lookup made in `XL_OFF` faults.
- R8: A lookup below BASE or at or above BASE + PAGES×4096 faults.
- R9: A lookup whose entry has bit 31 clear faults; writing an all-zero entry unmaps the page. A faulting response returns `lk_paddr` = 0.
- R10: The first page of the window maps to entry 0 and the last page maps to entry PAGES − 1.
- R11: A read of offset 0xC returns 0, and a write to offset 0xC changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| reg_rack | output | 1 | Read data valid |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup I/O virtual address |
| lk_rsp | output | 1 | Lookup response valid |
| lk_paddr | output | 32 | Translated physical address |
| lk_fault | output | 1 | Lookup fault |

## Verification
Register read data and lookup results are both due exactly one cycle after their strobe. Writes to the registers and the table take effect at the clock edge that samples them, so a lookup issued in the following cycle already sees the new entry. The driver tasks push each expected value into a queue as they apply the strobe. The monitor compares values only on the falling edge of cycles in which `reg_rack` or `lk_rsp` is high, so each comparison falls in the cycle where its result is due. The monitor also counts a response that arrives with no expectation queued, or an expectation still queued at the end, as a miscompare.

// File: rtl/aprt_pkg.sv
package aprt_pkg;
    localparam int unsigned PAGE_SHIFT = 12;
    localparam int unsigned VALID_BIT  = 31;
    localparam logic [3:0]  OFS_CFG    = 4'h0;
    localparam logic [3:0]  OFS_EPTR   = 4'h4;
    localparam logic [3:0]  OFS_EDATA  = 4'h8;

    typedef enum logic {
        XL_OFF = 1'b0,
        XL_ON  = 1'b1
    } xlate_state_t;
endpackage

// File: rtl/aprt_window.sv
module aprt_window
    import aprt_pkg::*;
#(
    parameter logic [31:0] BASE  = 32'h4000_0000,
    parameter int unsigned PAGES = 64,
    parameter int unsigned IDX_W = 6
) (
    input  logic [31:0]      addr,
    output logic             in_win,
    output logic [IDX_W-1:0] idx
);
    localparam logic [32:0] LIMIT = {1'b0, BASE} + (33'(PAGES) << PAGE_SHIFT);

    logic [31:0] offs;

    always_comb begin
        offs   = addr - BASE;
        in_win = (addr >= BASE) && ({1'b0, addr} < LIMIT);
        idx    = offs[PAGE_SHIFT +: IDX_W];
    end
endmodule

// File: rtl/aprt_table.sv
module aprt_table #(
    parameter int unsigned PAGES = 64,
    parameter int unsigned IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [31:0]      wdata,
    input  logic [IDX_W-1:0] ridx_a,
    output logic [31:0]      rdata_a,
    input  logic [IDX_W-1:0] ridx_b,
    output logic [31:0]      rdata_b
);
    logic [31:0] ent [PAGES];

    for (genvar g = 0; g < PAGES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent[g] <= '0;
            else if (we && (widx == IDX_W'(g)))
                ent[g] <= wdata;
        end
    end

    always_comb begin
        rdata_a = '0;
        rdata_b = '0;
        for (int i = 0; i < PAGES; i++) begin
            if (ridx_a == IDX_W'(i)) rdata_a = ent[i];
            if (ridx_b == IDX_W'(i)) rdata_b = ent[i];
        end
    end
endmodule

// File: rtl/aprt_ctrl.sv
module aprt_ctrl
    import aprt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    input  logic        ptr_in_win,
    input  logic [31:0] ptr_entry,
    output logic [31:0] eptr,
    output logic        ent_we,
    output logic [31:0] reg_rdata,
    output logic        reg_rack,
    output logic        xlate_on
);
    xlate_state_t state_q, state_d;
    logic         cfg_wr;
    logic [31:0]  rd_mux;

    assign cfg_wr = reg_wr && (reg_addr == OFS_CFG);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XL_OFF: if (cfg_wr &&  reg_wdata[0]) state_d = XL_ON;
            XL_ON:  if (cfg_wr && !reg_wdata[0]) state_d = XL_OFF;
            default: state_d = XL_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= XL_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        xlate_on = (state_q == XL_ON);
        ent_we   = reg_wr && (reg_addr == OFS_EDATA) && ptr_in_win;
        unique case (reg_addr)
            OFS_CFG:   rd_mux = {31'b0, xlate_on};
            OFS_EPTR:  rd_mux = eptr;
            OFS_EDATA: rd_mux = ptr_in_win ? ptr_entry : 32'b0;
            default:   rd_mux = 32'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eptr      <= '0;
            reg_rack  <= 1'b0;
            reg_rdata <= '0;
        end else begin
            if (reg_wr && (reg_addr == OFS_EPTR))
                eptr <= reg_wdata;
            reg_rack  <= reg_rd;
            reg_rdata <= reg_rd ? rd_mux : 32'b0;
        end
    end
endmodule

// File: rtl/aprt_remap.sv
module aprt_remap
    import aprt_pkg::*;
#(
    parameter logic [31:0] BASE  = 32'h4000_0000,
    parameter int unsigned PAGES = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        reg_rack,
    input  logic        lk_req,
    input  logic [31:0] lk_addr,
    output logic        lk_rsp,
    output logic [31:0] lk_paddr,
    output logic        lk_fault
);
    localparam int unsigned IDX_W = (PAGES > 1) ? $clog2(PAGES) : 1;

    logic [31:0]      eptr, ptr_entry, lk_entry;
    logic             ptr_in_win, lk_in_win, ent_we, xlate_on;
    logic [IDX_W-1:0] ptr_idx, lk_idx;
    logic             lk_hit;

    aprt_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .ptr_in_win(ptr_in_win), .ptr_entry(ptr_entry),
        .eptr(eptr), .ent_we(ent_we), .reg_rdata(reg_rdata),
        .reg_rack(reg_rack), .xlate_on(xlate_on)
    );

    aprt_window #(.BASE(BASE), .PAGES(PAGES), .IDX_W(IDX_W)) u_ptr_win (
        .addr(eptr), .in_win(ptr_in_win), .idx(ptr_idx)
    );

    aprt_window #(.BASE(BASE), .PAGES(PAGES), .IDX_W(IDX_W)) u_lk_win (
        .addr(lk_addr), .in_win(lk_in_win), .idx(lk_idx)
    );

    aprt_table #(.PAGES(PAGES), .IDX_W(IDX_W)) u_tbl (
        .clk(clk), .rst_n(rst_n), .we(ent_we), .widx(ptr_idx),
        .wdata(reg_wdata), .ridx_a(ptr_idx), .rdata_a(ptr_entry),
        .ridx_b(lk_idx), .rdata_b(lk_entry)
    );

    assign lk_hit = xlate_on && lk_in_win && lk_entry[VALID_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_rsp   <= 1'b0;
            lk_fault <= 1'b0;
            lk_paddr <= '0;
        end else begin
            lk_rsp   <= lk_req;
            lk_fault <= lk_req && !lk_hit;
            lk_paddr <= (lk_req && lk_hit)
                        ? {1'b0, lk_entry[30:PAGE_SHIFT], lk_addr[PAGE_SHIFT-1:0]}
                        : 32'b0;
        end
    end
endmodule

// File: rtl/aprt_remap_chk.sv
module aprt_remap_chk #(
    parameter logic [31:0] BASE  = 32'h4000_0000,
    parameter int unsigned PAGES = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_rd,
    input logic        reg_rack,
    input logic        lk_req,
    input logic [31:0] lk_addr,
    input logic        lk_rsp,
    input logic [31:0] lk_paddr,
    input logic        lk_fault,
    input logic        xlate_on
);
    localparam logic [32:0] LIMIT = {1'b0, BASE} + (33'(PAGES) << 12);

    logic outside;
    assign outside = (lk_addr < BASE) || ({1'b0, lk_addr} >= LIMIT);

    p_rsp_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_rsp);
    p_no_spurious_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !lk_rsp);
    p_offset_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (lk_fault || (lk_paddr[11:0] == $past(lk_addr[11:0]))));
    p_fault_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !xlate_on) |=> lk_fault);
    p_fault_outside_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && outside) |=> lk_fault);
    p_fault_zero_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_rsp && lk_fault) |-> (lk_paddr == 32'b0));
    p_read_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rack);
endmodule

bind aprt_remap aprt_remap_chk #(.BASE(BASE), .PAGES(PAGES)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_rack(reg_rack),
    .lk_req(lk_req), .lk_addr(lk_addr), .lk_rsp(lk_rsp),
    .lk_paddr(lk_paddr), .lk_fault(lk_fault), .xlate_on(xlate_on)
);

// File: tb/sim_aprt_remap.sv
`timescale 1ns/1ps
module sim_aprt_remap;
    localparam logic [31:0] BASE  = 32'h4000_0000;
    localparam int unsigned PAGES = 64;
    localparam logic [32:0] LIMIT = {1'b0, BASE} + (33'(PAGES) << 12);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, lk_req = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, lk_addr = '0;
    logic [31:0] reg_rdata, lk_paddr;
    logic        reg_rack, lk_rsp, lk_fault;

    always #2 clk = ~clk;

    aprt_remap #(.BASE(BASE), .PAGES(PAGES)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rack(reg_rack), .lk_req(lk_req), .lk_addr(lk_addr),
        .lk_rsp(lk_rsp), .lk_paddr(lk_paddr), .lk_fault(lk_fault)
    );

    int n_vec = 0, n_bad = 0;
    bit done = 1'b0;

    string       rd_tag[$];
    logic [31:0] rd_exp[$];
    string       lk_tag[$];
    logic [32:0] lk_exp[$];

    logic [31:0] m_ent [PAGES];
    logic        m_on;
    logic [31:0] m_ptr;

    function automatic bit in_win(logic [31:0] a);
        return (a >= BASE) && ({1'b0, a} < LIMIT);
    endfunction

    function automatic int widx(logic [31:0] a);
        logic [31:0] o;
        o = a - BASE;
        return int'(o[31:12]);
    endfunction

    task automatic check(string tag, logic [32:0] act, logic [32:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] ofs, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = ofs; reg_wdata = d;
        if (ofs == 4'h0) m_on = d[0];
        if (ofs == 4'h4) m_ptr = d;
        if (ofs == 4'h8 && in_win(m_ptr)) m_ent[widx(m_ptr)] = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] ofs, string tag);
        logic [31:0] e;
        case (ofs)
            4'h0:    e = {31'b0, m_on};
            4'h4:    e = m_ptr;
            4'h8:    e = in_win(m_ptr) ? m_ent[widx(m_ptr)] : 32'b0;
            default: e = 32'b0;
        endcase
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = ofs;
        rd_tag.push_back(tag); rd_exp.push_back(e);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic look(logic [31:0] a, string tag);
        logic [32:0] e;
        logic [31:0] en;
        en = in_win(a) ? m_ent[widx(a)] : 32'b0;
        if (m_on && in_win(a) && en[31])
            e = {1'b0, 1'b0, en[30:12], a[11:0]};
        else
            e = {1'b1, 32'b0};
        @(negedge clk);
        lk_req = 1'b1; lk_addr = a;
        lk_tag.push_back(tag); lk_exp.push_back(e);
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (reg_rack) begin
                if (rd_exp.size() == 0) check("read without request R4", {1'b0, reg_rdata}, 33'h1_FFFF_FFFF);
                else check(rd_tag.pop_front(), {1'b0, reg_rdata}, {1'b0, rd_exp.pop_front()});
            end
            if (lk_rsp) begin
                if (lk_exp.size() == 0) check("response without request R6", {lk_fault, lk_paddr}, 33'h1_FFFF_FFFF);
                else check(lk_tag.pop_front(), {lk_fault, lk_paddr}, lk_exp.pop_front());
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        done = 1'b1;
        n_vec++; n_bad++;
        $display("FAIL watchdog R1..all actual=timeout expected=finish");
        summary();
    end

    initial begin
        for (int i = 0; i < PAGES; i++) m_ent[i] = '0;
        m_on = 1'b0; m_ptr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset no read ack", {32'b0, reg_rack}, 33'h0);
        check("R1 reset no lookup rsp", {32'b0, lk_rsp}, 33'h0);
        rd(4'h0, "R1 cfg after reset");
        rd(4'h4, "R1 pointer after reset");
        rd(4'h8, "R1 data read at pointer 0");
        look(BASE, "R1 R7 lookup while off");

        wr(4'h0, 32'h1);
        rd(4'h0, "R2 cfg reads on");
        look(BASE + 32'h10, "R1 R9 invalid entry after reset");

        wr(4'h4, BASE);
        rd(4'h4, "R3 pointer readback");
        wr(4'h8, 32'h8001_2000);
        rd(4'h8, "R4 entry readback page 0");
        look(BASE + 32'h0abc, "R6 R10 first page translate");

        wr(4'h4, BASE + 32'h3_f123);
        wr(4'h8, 32'h8fff_f000);
        wr(4'h4, BASE + 32'h3_f000);
        rd(4'h8, "R4 R10 last entry readback");
        look(BASE + 32'h3_fffe, "R6 R10 last page translate");

        wr(4'h4, BASE + 32'h4_0000);
        wr(4'h8, 32'h8000_5000);
        rd(4'h8, "R5 outside pointer reads zero");
        look(BASE, "R5 ignored write left page 0");
        look(BASE + 32'h4_0000, "R8 at limit faults");
        look(BASE - 32'h1, "R8 below base faults");

        wr(4'h4, BASE + 32'h5000);
        wr(4'h8, 32'h0000_7000);
        look(BASE + 32'h5010, "R9 valid bit clear faults");
        wr(4'h8, 32'h8000_7000);
        look(BASE + 32'h5010, "R6 mid page translate");
        wr(4'h8, 32'h0);
        look(BASE + 32'h5010, "R9 zero entry unmaps");

        wr(4'h0, 32'h0);
        rd(4'h0, "R2 cfg reads off");
        look(BASE + 32'h20, "R7 lookup after disable");
        wr(4'h0, 32'h3);
        rd(4'h0, "R2 cfg bit0 enables");

        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'hC, "R11 unused offset reads zero");
        rd(4'h0, "R11 unused write left cfg");
        rd(4'h4, "R11 unused write left pointer");

        repeat (4) @(negedge clk);
        done = 1'b1;
        check("R4 R6 all expectations consumed",
              33'(rd_exp.size() + lk_exp.size()), 33'h0);
        summary();
    end
endmodule